// File: doc/BRIEF.md
# DDR Command Decoder with Bank Tracking

This block watches the command bus of a four-bank DDR SDRAM from the controller side. On every rising clock edge it samples chip select, the three strobes (row, column, write enable), clock enable, the bank address and the row/column address bus. From these it decodes one command. It also keeps, for each bank, whether a row is open and which row that is. Any command that breaks an ordering or spacing rule raises a flag.

All spacing rules are counted in whole clock cycles. The timing values are parameters given as cycle counts. The results are the decoded command, one violation bit per rule, the open/closed state of each bank and the open row of each bank. They are all registered on the same edge that samples the command. A command that raises any violation is treated as rejected: it leaves bank state and every timer unchanged.

The block is intended as a protocol monitor. It can sit beside a controller in a larger design, or it can serve as the reference for one. It does not handle data capture, electrical behaviour or the meaning of mode-register fields.

Top module: `ddr_cmd_monitor`

## Requirements
- R1: When chip select (`cs_n`) is sampled high, and clock enable is high on both this edge and the previous one, the result is `cmd_o` = 0 (NOP) with no violation bit set and no change to bank state.
- R2: With clock enable high on both edges and `cs_n` low, `{ras_n,cas_n,we_n}` decodes as follows: 000 gives 1 (mode set), 001 gives 2 (auto refresh), 010 gives precharge (4 with `addr[10]` low, 5 with it high), 011 gives 6 (activate), 100 gives write (7, or 8 with auto-precharge when `addr[10]` is high), 101 gives read (9, or 10 with auto-precharge), 110 gives 11 (burst stop) and 111 gives 0. When clock enable goes from high to low, the refresh pattern with `cs_n` low gives 3 (self-refresh entry) and any other pattern gives 12 (power-down entry). When clock enable goes from low to high the result is 13 (exit). While clock enable stays low the result is 0.
- R3: An accepted activate opens the bank numbered `ba` (value 0..3) and stores `addr` as its open row. `bank_active_o[i]` shows bank i, and `open_row_o[i*ROW_W +: ROW_W]` holds its row, which is kept after the bank closes. After reset all banks are idle with row 0.
- R4: An accepted precharge with `addr[10]` low closes only bank `ba`. With `addr[10]` high it closes every bank whatever `ba` holds.
- R5: A read or write to a bank that is not open sets `viol_o[0]`.
- R6: An activate to a bank that is already open sets `viol_o[1]`.
- R7: A mode set, auto refresh or self-refresh entry while any bank is open sets `viol_o[2]`.
- R8: Any command other than 0, issued fewer than TMRD cycles after an accepted mode set, sets `viol_o[3]`.
- R9: A read or write fewer than TRCD cycles after the activate of that bank sets `viol_o[4]`. A precharge that closes a bank fewer than TRAS cycles after its activate sets `viol_o[7]`.
- R10: An activate fewer than TRRD cycles after an accepted activate to a different bank sets `viol_o[5]`.
- R11: An activate to an idle bank sets `viol_o[6]` in two cases: fewer than TRP cycles after the precharge that closed it, or fewer than B+TRP cycles after a read or write with auto-precharge to it.
- R12: A precharge that closes a bank fewer than B+TWR cycles after an accepted write without auto-precharge to that bank sets `viol_o[8]`.
- R13: After an accepted read or write with auto-precharge, any read or write issued fewer than B cycles later sets `viol_o[9]`. B is the burst length in clocks taken from `burst_sel` at that command: 0 gives 1, 1 gives 2, and 2 or 3 give 4.
- R14: A command with any violation bit set changes no bank state or timer. An accepted read or write with auto-precharge closes its bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock, rising edge samples |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| cke | input | 1 | Clock enable |
| ba | input | BA_W | Bank address |
| addr | input | ROW_W | Row/column address; bit 10 selects auto-precharge or all banks |
| burst_sel | input | 2 | Burst length select for the auto-precharge lockout |
| cmd_o | output | 4 | Decoded command code |
| viol_o | output | 10 | One strobe per violated rule |
| bank_active_o | output | 2**BA_W | Per-bank open flag |
| open_row_o | output | 2**BA_W*ROW_W | Open row for each bank |

## Verification
The embedded assertions assume three things about the inputs: every control and address input holds a known value at each rising edge once reset is released, `cke` is held high during reset, and all timing parameters are at least one cycle. The bench meets these by changing inputs only on the falling edge and always with defined values. It keeps `cke` high through reset and uses the default timing counts. Its random mix is weighted toward activates, column commands and precharges, so that open banks and spacing conflicts happen often, and it drops `cke` only for short runs.

// File: rtl/ddrmon_pkg.sv
// Shared types for the DDR command monitor.
// Assumes a four-bit command code and a fixed order of violation bits,
// which neighbouring logic and software decode by position.
package ddrmon_pkg;

    typedef enum logic [3:0] {
        CMD_NOP    = 4'd0,
        CMD_MRS    = 4'd1,
        CMD_AREF   = 4'd2,
        CMD_SREF   = 4'd3,
        CMD_PRE    = 4'd4,
        CMD_PREALL = 4'd5,
        CMD_ACT    = 4'd6,
        CMD_WR     = 4'd7,
        CMD_WRA    = 4'd8,
        CMD_RD     = 4'd9,
        CMD_RDA    = 4'd10,
        CMD_BST    = 4'd11,
        CMD_PDE    = 4'd12,
        CMD_CKX    = 4'd13
    } cmd_e;

    localparam int V_NOT_OPEN = 0;
    localparam int V_BUSY     = 1;
    localparam int V_NOT_IDLE = 2;
    localparam int V_MRD      = 3;
    localparam int V_RCD      = 4;
    localparam int V_RRD      = 5;
    localparam int V_RP       = 6;
    localparam int V_RAS      = 7;
    localparam int V_WR       = 8;
    localparam int V_LOCK     = 9;
    localparam int V_N        = 10;

    // Burst length select to burst duration in clocks.
    function automatic logic [2:0] burst_clocks(input logic [1:0] sel);
        case (sel)
            2'd0:    burst_clocks = 3'd1;
            2'd1:    burst_clocks = 3'd2;
            default: burst_clocks = 3'd4;
        endcase
    endfunction

    // True for any read or write, with or without auto-precharge.
    function automatic logic is_col(input cmd_e c);
        is_col = (c == CMD_WR) || (c == CMD_WRA) || (c == CMD_RD) || (c == CMD_RDA);
    endfunction

endpackage

// File: rtl/ddrmon_decode.sv
// Command decoder: maps the sampled pins to one command code.
// Assumes cke_q holds the clock enable seen on the previous edge.
// Purely combinational; the caller registers the result.
module ddrmon_decode
    import ddrmon_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    input  logic cke_q,
    input  logic ap,
    output cmd_e cmd
);

    logic [2:0] pat;
    assign pat = {ras_n, cas_n, we_n};

    // Pick the command from clock-enable transition and strobe pattern.
    always_comb begin
        cmd = CMD_NOP;
        if (!cke_q) begin
            cmd = cke ? CMD_CKX : CMD_NOP;
        end else if (!cke) begin
            cmd = (!cs_n && pat == 3'b001) ? CMD_SREF : CMD_PDE;
        end else if (!cs_n) begin
            case (pat)
                3'b000:  cmd = CMD_MRS;
                3'b001:  cmd = CMD_AREF;
                3'b010:  cmd = ap ? CMD_PREALL : CMD_PRE;
                3'b011:  cmd = CMD_ACT;
                3'b100:  cmd = ap ? CMD_WRA : CMD_WR;
                3'b101:  cmd = ap ? CMD_RDA : CMD_RD;
                3'b110:  cmd = CMD_BST;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/ddrmon_bank.sv
// Per-bank tracker: open flag, open row and four spacing timers.
// Assumes at most one of do_act, do_pre, do_ap is high in a cycle and that
// each strobe is raised only for accepted commands. A timer loaded with
// T-1 reads busy for the next T-1 edges.
module ddrmon_bank #(
    parameter int ROW_W = 12,
    parameter int CW    = 5,
    parameter int TRCD  = 2,
    parameter int TRAS  = 6,
    parameter int TRP   = 2,
    parameter int TWR   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_act,
    input  logic             do_pre,
    input  logic             do_wr,
    input  logic             do_ap,
    input  logic [ROW_W-1:0] row_in,
    input  logic [CW-1:0]    bclk,
    output logic             active,
    output logic [ROW_W-1:0] row,
    output logic             rcd_busy,
    output logic             ras_busy,
    output logic             rp_busy,
    output logic             wr_busy
);

    logic [CW-1:0] rcd_cnt, ras_cnt, rp_cnt, wr_cnt;

    // Open and close the bank and remember the row.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            row    <= '0;
        end else if (do_act) begin
            active <= 1'b1;
            row    <= row_in;
        end else if (do_ap || do_pre) begin
            active <= 1'b0;
        end
    end

    // Activate-to-column and activate-to-precharge timers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcd_cnt <= '0;
            ras_cnt <= '0;
        end else if (do_act) begin
            rcd_cnt <= CW'(TRCD - 1);
            ras_cnt <= CW'(TRAS - 1);
        end else begin
            if (rcd_cnt != '0) rcd_cnt <= rcd_cnt - CW'(1);
            if (ras_cnt != '0) ras_cnt <= ras_cnt - CW'(1);
        end
    end

    // Precharge-to-activate timer, stretched by the burst for auto-precharge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_cnt <= '0;
        end else if (do_pre && active) begin
            rp_cnt <= CW'(TRP - 1);
        end else if (do_ap) begin
            rp_cnt <= bclk + CW'(TRP - 1);
        end else if (rp_cnt != '0) begin
            rp_cnt <= rp_cnt - CW'(1);
        end
    end

    // Write recovery timer, counted from the end of the write burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt <= '0;
        end else if (do_wr) begin
            wr_cnt <= bclk + CW'(TWR - 1);
        end else if (wr_cnt != '0) begin
            wr_cnt <= wr_cnt - CW'(1);
        end
    end

    assign rcd_busy = (rcd_cnt != '0);
    assign ras_busy = (ras_cnt != '0);
    assign rp_busy  = (rp_cnt  != '0);
    assign wr_busy  = (wr_cnt  != '0);

    // R3: an accepted activate leaves the bank open on the next cycle.
    a_r3_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
        do_act |=> active);

endmodule

// File: rtl/ddrmon_global.sv
// Bus-wide timers: mode-set settle, activate-to-activate spacing and the
// auto-precharge column lockout. Assumes strobes mark accepted commands only.
module ddrmon_global #(
    parameter int BA_W = 2,
    parameter int CW   = 5,
    parameter int TMRD = 2,
    parameter int TRRD = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            do_mrs,
    input  logic            do_act,
    input  logic [BA_W-1:0] act_bank,
    input  logic            do_ap,
    input  logic [CW-1:0]   bclk,
    output logic            mrd_busy,
    output logic            rrd_busy,
    output logic [BA_W-1:0] last_bank,
    output logic            lock_busy
);

    logic [CW-1:0] mrd_cnt, rrd_cnt, lock_cnt;

    // Mode-set settle window.
    always_ff @(posedge clk) begin
        if (!rst_n)                mrd_cnt <= '0;
        else if (do_mrs)           mrd_cnt <= CW'(TMRD - 1);
        else if (mrd_cnt != '0)    mrd_cnt <= mrd_cnt - CW'(1);
    end

    // Activate spacing and the bank it was aimed at.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrd_cnt   <= '0;
            last_bank <= '0;
        end else if (do_act) begin
            rrd_cnt   <= CW'(TRRD - 1);
            last_bank <= act_bank;
        end else if (rrd_cnt != '0) begin
            rrd_cnt <= rrd_cnt - CW'(1);
        end
    end

    // Column lockout for the length of an auto-precharge burst.
    always_ff @(posedge clk) begin
        if (!rst_n)                lock_cnt <= '0;
        else if (do_ap)            lock_cnt <= bclk - CW'(1);
        else if (lock_cnt != '0)   lock_cnt <= lock_cnt - CW'(1);
    end

    assign mrd_busy  = (mrd_cnt  != '0);
    assign rrd_busy  = (rrd_cnt  != '0);
    assign lock_busy = (lock_cnt != '0);

endmodule

// File: rtl/ddr_cmd_monitor.sv
// DDR command monitor top: decodes each sampled command, checks it against
// live bank state and spacing timers, and registers the command code and
// one violation strobe per rule. A flagged command is rejected and changes
// no state. Assumes ROW_W > AP_BIT and all timing counts of at least 1.
module ddr_cmd_monitor
    import ddrmon_pkg::*;
#(
    parameter int BA_W   = 2,
    parameter int ROW_W  = 12,
    parameter int AP_BIT = 10,
    parameter int TRCD   = 2,
    parameter int TRP    = 2,
    parameter int TRRD   = 2,
    parameter int TRAS   = 6,
    parameter int TWR    = 2,
    parameter int TMRD   = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cs_n,
    input  logic                          ras_n,
    input  logic                          cas_n,
    input  logic                          we_n,
    input  logic                          cke,
    input  logic [BA_W-1:0]               ba,
    input  logic [ROW_W-1:0]              addr,
    input  logic [1:0]                    burst_sel,
    output logic [3:0]                    cmd_o,
    output logic [V_N-1:0]                viol_o,
    output logic [(1<<BA_W)-1:0]          bank_active_o,
    output logic [(1<<BA_W)*ROW_W-1:0]    open_row_o
);

    localparam int BANKS = 1 << BA_W;
    localparam int MAXT  = TRCD + TRAS + TRP + TWR + TRRD + TMRD + 4;
    localparam int CW    = $clog2(MAXT + 1);

    logic             cke_q;
    cmd_e             cmd_c, cmd_q;
    logic [V_N-1:0]   viol_c;
    logic             accept, col;
    logic [CW-1:0]    bclk;
    logic [BANKS-1:0] tgt;
    logic [BANKS-1:0] act_v, rcd_b, ras_b, rp_b, wr_b;
    logic [BANKS-1:0] do_act, do_pre, do_wr, do_ap;
    logic             mrd_busy, rrd_busy, lock_busy;
    logic [BA_W-1:0]  last_bank;

    ddrmon_decode u_dec (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cke   (cke),
        .cke_q (cke_q),
        .ap    (addr[AP_BIT]),
        .cmd   (cmd_c)
    );

    assign col  = is_col(cmd_c);
    assign bclk = CW'(burst_clocks(burst_sel));
    assign tgt  = BANKS'(1) << ba;

    // Evaluate every rule against the state before this edge.
    always_comb begin
        viol_c             = '0;
        viol_c[V_NOT_OPEN] = col && !act_v[ba];
        viol_c[V_BUSY]     = (cmd_c == CMD_ACT) && act_v[ba];
        viol_c[V_NOT_IDLE] = ((cmd_c == CMD_MRS) || (cmd_c == CMD_AREF) ||
                              (cmd_c == CMD_SREF)) && (|act_v);
        viol_c[V_MRD]      = (cmd_c != CMD_NOP) && mrd_busy;
        viol_c[V_RCD]      = col && act_v[ba] && rcd_b[ba];
        viol_c[V_RRD]      = (cmd_c == CMD_ACT) && rrd_busy && (last_bank != ba);
        viol_c[V_RP]       = (cmd_c == CMD_ACT) && !act_v[ba] && rp_b[ba];
        viol_c[V_RAS]      = ((cmd_c == CMD_PRE) && act_v[ba] && ras_b[ba]) ||
                             ((cmd_c == CMD_PREALL) && (|(act_v & ras_b)));
        viol_c[V_WR]       = ((cmd_c == CMD_PRE) && act_v[ba] && wr_b[ba]) ||
                             ((cmd_c == CMD_PREALL) && (|(act_v & wr_b)));
        viol_c[V_LOCK]     = col && lock_busy;
    end

    assign accept = (viol_c == '0);

    // Per-bank update strobes for accepted commands only.
    always_comb begin
        for (int i = 0; i < BANKS; i++) begin
            do_act[i] = accept && (cmd_c == CMD_ACT) && tgt[i];
            do_pre[i] = accept && (((cmd_c == CMD_PRE) && tgt[i]) || (cmd_c == CMD_PREALL));
            do_wr[i]  = accept && (cmd_c == CMD_WR) && tgt[i];
            do_ap[i]  = accept && ((cmd_c == CMD_WRA) || (cmd_c == CMD_RDA)) && tgt[i];
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < BANKS; gi++) begin : g_bank
            logic [ROW_W-1:0] row_g;
            ddrmon_bank #(
                .ROW_W (ROW_W),
                .CW    (CW),
                .TRCD  (TRCD),
                .TRAS  (TRAS),
                .TRP   (TRP),
                .TWR   (TWR)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .do_act   (do_act[gi]),
                .do_pre   (do_pre[gi]),
                .do_wr    (do_wr[gi]),
                .do_ap    (do_ap[gi]),
                .row_in   (addr),
                .bclk     (bclk),
                .active   (act_v[gi]),
                .row      (row_g),
                .rcd_busy (rcd_b[gi]),
                .ras_busy (ras_b[gi]),
                .rp_busy  (rp_b[gi]),
                .wr_busy  (wr_b[gi])
            );
            assign open_row_o[gi*ROW_W +: ROW_W] = row_g;
        end
    endgenerate

    ddrmon_global #(
        .BA_W (BA_W),
        .CW   (CW),
        .TMRD (TMRD),
        .TRRD (TRRD)
    ) u_glob (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_mrs    (accept && (cmd_c == CMD_MRS)),
        .do_act    (accept && (cmd_c == CMD_ACT)),
        .act_bank  (ba),
        .do_ap     (accept && ((cmd_c == CMD_WRA) || (cmd_c == CMD_RDA))),
        .bclk      (bclk),
        .mrd_busy  (mrd_busy),
        .rrd_busy  (rrd_busy),
        .last_bank (last_bank),
        .lock_busy (lock_busy)
    );

    // Register clock enable history, command code and violation strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cke_q  <= 1'b1;
            cmd_q  <= CMD_NOP;
            viol_o <= '0;
        end else begin
            cke_q  <= cke;
            cmd_q  <= cmd_c;
            viol_o <= viol_c;
        end
    end

    assign cmd_o         = cmd_q;
    assign bank_active_o = act_v;

    // R1: a deselected cycle with clock enable steady reports a quiet NOP.
    a_r1_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && cke && cke_q) |=> (cmd_o == 4'd0 && viol_o == '0));

    // R4: an accepted all-bank precharge leaves every bank idle.
    a_r4_preall_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_c == CMD_PREALL && accept) |=> (bank_active_o == '0));

    // R14: a rejected command leaves bank flags and rows untouched.
    a_r14_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (|viol_c) |=> ($stable(bank_active_o) && $stable(open_row_o)));

    // R5: the not-open strobe only ever accompanies a column command.
    a_r5_flag_is_column: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o[V_NOT_OPEN] |-> is_col(cmd_q));

endmodule

// File: tb/ddr_cmd_monitor_bench.sv
module ddr_cmd_monitor_bench;

    localparam int TRCD = 2, TRP = 2, TRRD = 2, TRAS = 6, TWR = 2, TMRD = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs_n, ras_n, cas_n, we_n, cke;
    logic [1:0]  ba;
    logic [11:0] addr;
    logic [1:0]  burst_sel;
    logic [3:0]  cmd_o;
    logic [9:0]  viol_o;
    logic [3:0]  bank_active_o;
    logic [47:0] open_row_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ddr_cmd_monitor u_ddr_cmd_monitor (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .cke(cke), .ba(ba), .addr(addr), .burst_sel(burst_sel),
        .cmd_o(cmd_o), .viol_o(viol_o), .bank_active_o(bank_active_o),
        .open_row_o(open_row_o)
    );

    // Reference state, kept as cycle stamps rather than counters.
    bit m_act [4];
    int m_row [4];
    int t_col [4], t_ras [4], t_actok [4], t_wr [4];
    int t_mrd, t_rrd, t_lock, last_b, cyc;
    bit m_ckeq;

    function automatic string vtag(input int i);
        case (i)
            0: return "R5";  1: return "R6";  2: return "R7";  3: return "R8";
            4: return "R9";  5: return "R10"; 6: return "R11"; 7: return "R9";
            8: return "R12"; default: return "R13";
        endcase
    endfunction

    function automatic int model_decode(input bit ckeq, input logic c, r, ca, w, k, a10);
        if (!ckeq) return k ? 13 : 0;
        if (!k) return (!c && {r, ca, w} == 3'b001) ? 3 : 12;
        if (c) return 0;
        case ({r, ca, w})
            3'b000: return 1;
            3'b001: return 2;
            3'b010: return a10 ? 5 : 4;
            3'b011: return 6;
            3'b100: return a10 ? 8 : 7;
            3'b101: return a10 ? 10 : 9;
            3'b110: return 11;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic i_cs, i_ras, i_cas, i_we, i_cke,
                        input logic [1:0] i_ba, input logic [11:0] i_addr, input logic [1:0] i_bs);
        int ec, b, bcl;
        bit col, anyact;
        logic [9:0] ev;
        @(negedge clk);
        cs_n = i_cs; ras_n = i_ras; cas_n = i_cas; we_n = i_we; cke = i_cke;
        ba = i_ba; addr = i_addr; burst_sel = i_bs;
        ec  = model_decode(m_ckeq, i_cs, i_ras, i_cas, i_we, i_cke, i_addr[10]);
        b   = int'(i_ba);
        bcl = (i_bs == 2'd0) ? 1 : (i_bs == 2'd1) ? 2 : 4;
        col = (ec == 7) || (ec == 8) || (ec == 9) || (ec == 10);
        anyact = m_act[0] | m_act[1] | m_act[2] | m_act[3];
        ev = '0;
        ev[0] = col && !m_act[b];
        ev[1] = (ec == 6) && m_act[b];
        ev[2] = (ec == 1 || ec == 2 || ec == 3) && anyact;
        ev[3] = (ec != 0) && (cyc < t_mrd);
        ev[4] = col && m_act[b] && (cyc < t_col[b]);
        ev[5] = (ec == 6) && (cyc < t_rrd) && (last_b != b);
        ev[6] = (ec == 6) && !m_act[b] && (cyc < t_actok[b]);
        ev[7] = (ec == 4) && m_act[b] && (cyc < t_ras[b]);
        ev[8] = (ec == 4) && m_act[b] && (cyc < t_wr[b]);
        if (ec == 5)
            for (int j = 0; j < 4; j++) begin
                if (m_act[j] && cyc < t_ras[j]) ev[7] = 1'b1;
                if (m_act[j] && cyc < t_wr[j])  ev[8] = 1'b1;
            end
        ev[9] = col && (cyc < t_lock);
        @(posedge clk);
        #2;
        chk((m_ckeq && i_cke && i_cs) ? "R1" : "R2", "cmd", int'(cmd_o), ec);
        for (int i = 0; i < 10; i++) chk(vtag(i), $sformatf("viol[%0d]", i), int'(viol_o[i]), int'(ev[i]));
        if (ev == '0) begin
            case (ec)
                1: t_mrd = cyc + TMRD;
                6: begin
                    m_act[b] = 1; m_row[b] = int'(i_addr);
                    t_col[b] = cyc + TRCD; t_ras[b] = cyc + TRAS;
                    t_rrd = cyc + TRRD; last_b = b;
                end
                4: if (m_act[b]) begin m_act[b] = 0; t_actok[b] = cyc + TRP; end
                5: for (int j = 0; j < 4; j++)
                       if (m_act[j]) begin m_act[j] = 0; t_actok[j] = cyc + TRP; end
                7: t_wr[b] = cyc + bcl + TWR;
                8, 10: begin
                    m_act[b] = 0; t_actok[b] = cyc + bcl + TRP; t_lock = cyc + bcl;
                end
                default: ;
            endcase
        end
        for (int j = 0; j < 4; j++) begin
            chk((ev != '0) ? "R14" : "R4", $sformatf("bank_active[%0d]", j),
                int'(bank_active_o[j]), int'(m_act[j]));
            chk("R3", $sformatf("open_row[%0d]", j), int'(open_row_o[j*12 +: 12]), m_row[j]);
        end
        m_ckeq = i_cke;
        cyc++;
    endtask

    // Command shorthands: cs, ras, cas, we, cke.
    task automatic nop();                   step(1, 1, 1, 1, 1, 2'd0, 12'h000, 2'd0); endtask
    task automatic act(input int b, input int r);  step(0, 0, 1, 1, 1, 2'(b), 12'(r), 2'd0); endtask
    task automatic rd(input int b, input bit ap, input int bs);
        step(0, 1, 0, 1, 1, 2'(b), ap ? 12'h400 : 12'h000, 2'(bs)); endtask
    task automatic wr(input int b, input bit ap, input int bs);
        step(0, 1, 0, 0, 1, 2'(b), ap ? 12'h400 : 12'h000, 2'(bs)); endtask
    task automatic pre(input int b, input bit all);
        step(0, 0, 1, 0, 1, 2'(b), all ? 12'h400 : 12'h000, 2'd0); endtask
    task automatic mrs();  step(0, 0, 0, 0, 1, 2'd0, 12'h032, 2'd0); endtask
    task automatic aref(); step(0, 0, 0, 1, 1, 2'd0, 12'h000, 2'd0); endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'd20240611);
        for (int j = 0; j < 4; j++) begin
            m_act[j] = 0; m_row[j] = 0; t_col[j] = 0; t_ras[j] = 0; t_actok[j] = 0; t_wr[j] = 0;
        end
        t_mrd = 0; t_rrd = 0; t_lock = 0; last_b = 0; cyc = 0; m_ckeq = 1;
        rst_n = 0; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; cke = 1;
        ba = 0; addr = 0; burst_sel = 0;
        repeat (3) @(posedge clk);
        #2;
        // R3 reset state: idle banks, row 0, NOP, no strobes.
        chk("R3", "reset bank_active", int'(bank_active_o), 0);
        chk("R3", "reset open_row", int'(open_row_o != 0), 0);
        chk("R1", "reset cmd", int'(cmd_o), 0);
        chk("R1", "reset viol", int'(viol_o), 0);
        @(negedge clk);
        rst_n = 1;

        // R3/R9: open bank 2, read too early, read on time, precharge too early.
        act(2, 12'hABC); rd(2, 0, 0); rd(2, 0, 0); pre(2, 0);
        // R10: activate bank 0, then bank 1 straight after.
        act(0, 12'h123); act(1, 12'h456);
        // R5/R6/R7: read an idle bank, reopen an open bank, mode set with banks open.
        rd(3, 0, 0); act(0, 12'h777); mrs(); aref();
        // R12: write then precharge inside recovery; R11: reopen inside tRP.
        nop(); nop(); wr(0, 0, 1); pre(0, 0); nop(); nop(); nop(); pre(0, 0); act(0, 12'h0F0);
        nop(); act(0, 12'h0F1);
        // R4: precharge all with a nonzero bank address.
        repeat (6) nop();
        pre(3, 1);
        // R8: mode set then a command at once, then after the window.
        mrs(); aref(); aref();
        // R13/R14/R11: auto-precharge read of 4 clocks, column command in lockout,
        // reopen before burst plus tRP.
        act(1, 12'h321); nop(); act(2, 12'h654); nop();
        rd(1, 1, 2); rd(2, 0, 0); nop(); act(1, 12'h111); nop(); rd(2, 0, 0);
        nop(); nop(); act(1, 12'h222);
        // R13: burst select 0 gives no lockout; write with auto-precharge.
        nop(); nop(); wr(1, 1, 0); rd(2, 0, 3);
        // R2: power-down entry, ignored command while low, exit; self-refresh entry.
        repeat (6) nop();
        pre(0, 1);
        step(1, 1, 1, 1, 0, 2'd0, 12'h0, 2'd0);
        step(0, 0, 1, 1, 0, 2'd1, 12'h5, 2'd0);
        step(1, 1, 1, 1, 1, 2'd0, 12'h0, 2'd0);
        nop();
        step(0, 0, 0, 1, 0, 2'd0, 12'h0, 2'd0);
        step(1, 1, 1, 1, 1, 2'd0, 12'h0, 2'd0);
        nop();

        // Weighted random traffic, all checked against the reference.
        for (int n = 0; n < 3000; n++) begin
            int sel, rb;
            logic [11:0] ra;
            logic k;
            sel = $urandom_range(0, 99);
            rb  = $urandom_range(0, 3);
            ra  = 12'($urandom);
            k   = ($urandom_range(0, 24) == 0) ? 1'b0 : 1'b1;
            if (sel < 25)      step(0, 0, 1, 1, k, 2'(rb), ra, 2'($urandom_range(0, 3)));
            else if (sel < 35) step(0, 1, 0, 1, k, 2'(rb), ra, 2'($urandom_range(0, 3)));
            else if (sel < 45) step(0, 1, 0, 0, k, 2'(rb), ra, 2'($urandom_range(0, 3)));
            else if (sel < 60) step(0, 0, 1, 0, k, 2'(rb), ra, 2'($urandom_range(0, 3)));
            else if (sel < 64) step(0, 0, 0, 0, k, 2'(rb), ra, 2'd0);
            else if (sel < 68) step(0, 0, 0, 1, k, 2'(rb), ra, 2'd0);
            else if (sel < 82) step(1, 1, 1, 1, k, 2'(rb), ra, 2'd0);
            else if (sel < 88) step(1, 1'($urandom), 1'($urandom), 1'($urandom), k, 2'(rb), ra, 2'd0);
            else if (sel < 92) step(0, 1, 1, 0, k, 2'(rb), ra, 2'd0);
            else               step(0, 1, 1, 1, k, 2'(rb), ra, 2'd0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule